// File: doc/BRIEF.md
# Converter Start-Up Data Gate Sequencer

This block controls the first sample periods after the digital audio path of a stereo converter is switched on. It watches the power-enable bits of the two ADC channels, the two digital-microphone channels and the DAC. When the capture path comes out of the fully-off state, it holds both capture sample outputs at zero for a window of sample periods. A 2-bit select picks the window length. The DAC path has its own fixed two-period window.

Time is counted only in sample periods. A one-cycle strobe, `fs_tick`, marks each period. The length select is taken at the moment the window starts, so later changes to it do not alter a window that is running. While a window runs, a busy flag is high for that path. Once the window ends, the samples pass through unchanged. A path whose enables are all low keeps its outputs at zero.

Top module: `codec_init_seq`

## Requirements
- R1: The capture group consists of four enables: ADC left, ADC right, mic left and mic right. A capture window starts on the first clock edge at which at least one of the four is high, when all four were low at the previous edge.
- R2: The window length is counted in `fs_tick` strobes. The count starts after the starting edge, and `adc_busy` falls at the edge that takes the last strobe. The `len_sel` codes give these lengths: 2'b00 gives 1059, 2'b01 gives 267, 2'b10 gives 531 and 2'b11 gives 135.
- R3: After reset, both busy flags are low. With all enables low, all four sample outputs are zero.
- R4: While `adc_busy` is high, `adc_out_l` and `adc_out_r` are both zero.
- R5: With the capture group on and no window running, each capture output equals its input.
- R6: A mic enable starts the window by the same all-off rule as an ADC enable, and the window has the same length.
- R7: Raising a further capture enable while another is already on does not restart or extend a running window.
- R8: Cycles without a strobe do not advance a window. A change to `len_sel` after the starting edge does not change that window's length.
- R9: When all four capture enables go low, a running window ends and the capture outputs are zero. A later enable starts a new window of full length.
- R10: A rising `dac_en` starts a DAC window of 2 strobes. During that window `dac_busy` is high and both DAC outputs are zero. After it, the outputs equal the inputs. While `dac_en` is low, the DAC outputs are zero and `dac_busy` is low.
- R11: Each busy flag is high exactly during the periods in which its path is held at zero by a window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fs_tick | input | 1 | One-cycle strobe per sample period |
| adc_en_l | input | 1 | Left ADC power enable |
| adc_en_r | input | 1 | Right ADC power enable |
| mic_en_l | input | 1 | Left digital-microphone enable |
| mic_en_r | input | 1 | Right digital-microphone enable |
| dac_en | input | 1 | DAC power enable |
| len_sel | input | 2 | Capture window length select |
| adc_in_l | input | DW | Left capture sample in, 2's complement |
| adc_in_r | input | DW | Right capture sample in, 2's complement |
| dac_in_l | input | DW | Left playback sample in |
| dac_in_r | input | DW | Right playback sample in |
| adc_out_l | output | DW | Gated left capture sample |
| adc_out_r | output | DW | Gated right capture sample |
| dac_out_l | output | DW | Gated left playback sample |
| dac_out_r | output | DW | Gated right playback sample |
| adc_busy | output | 1 | Capture window active |
| dac_busy | output | 1 | DAC window active |

## Verification
An enable change is registered at the next clock edge. From that edge onward, the busy flag and the zeroed outputs are visible. Each strobe acts at the edge where it is high. The flag therefore drops at the edge that takes the last strobe of the window. The bench drives every input on the falling edge and pulses one strobe at a time. It samples on the following falling edge, so each strobe's effect is read exactly one edge later. The bench counts strobes until the flag drops, and it compares that count with the length it computes from the select code for all four codes and all four capture enables.

// File: rtl/codec_init_seq.sv
module codec_init_seq #(
  parameter int DW      = 24,
  parameter int LEN_00  = 1059,
  parameter int LEN_01  = 267,
  parameter int LEN_10  = 531,
  parameter int LEN_11  = 135,
  parameter int DAC_LEN = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fs_tick,
  input  logic          adc_en_l,
  input  logic          adc_en_r,
  input  logic          mic_en_l,
  input  logic          mic_en_r,
  input  logic          dac_en,
  input  logic [1:0]    len_sel,
  input  logic [DW-1:0] adc_in_l,
  input  logic [DW-1:0] adc_in_r,
  input  logic [DW-1:0] dac_in_l,
  input  logic [DW-1:0] dac_in_r,
  output logic [DW-1:0] adc_out_l,
  output logic [DW-1:0] adc_out_r,
  output logic [DW-1:0] dac_out_l,
  output logic [DW-1:0] dac_out_r,
  output logic          adc_busy,
  output logic          dac_busy
);

  localparam int M01     = (LEN_00 > LEN_01) ? LEN_00 : LEN_01;
  localparam int M23     = (LEN_10 > LEN_11) ? LEN_10 : LEN_11;
  localparam int LEN_MAX = (M01 > M23) ? M01 : M23;
  localparam int CW      = $clog2(LEN_MAX + 1);
  localparam int DCW     = $clog2(DAC_LEN + 1);

  function automatic logic [CW-1:0] sel_len(input logic [1:0] s);
    case (s)
      2'b00:   return CW'(LEN_00);
      2'b01:   return CW'(LEN_01);
      2'b10:   return CW'(LEN_10);
      default: return CW'(LEN_11);
    endcase
  endfunction

  logic          grp_on, grp_q, dac_q;
  logic          abusy_q, dbusy_q;
  logic [CW-1:0]  cnt;
  logic [DCW-1:0] dcnt;
  logic          adc_zero, dac_zero;

  assign grp_on = adc_en_l | adc_en_r | mic_en_l | mic_en_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q   <= 1'b0;
      abusy_q <= 1'b0;
      cnt     <= '0;
    end else begin
      grp_q <= grp_on;
      if (!grp_on) begin
        abusy_q <= 1'b0;
        cnt     <= '0;
      end else if (!grp_q) begin
        abusy_q <= 1'b1;
        cnt     <= sel_len(len_sel);
      end else if (abusy_q && fs_tick) begin
        if (cnt == CW'(1)) begin
          abusy_q <= 1'b0;
          cnt     <= '0;
        end else begin
          cnt <= cnt - CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dac_q   <= 1'b0;
      dbusy_q <= 1'b0;
      dcnt    <= '0;
    end else begin
      dac_q <= dac_en;
      if (!dac_en) begin
        dbusy_q <= 1'b0;
        dcnt    <= '0;
      end else if (!dac_q) begin
        dbusy_q <= 1'b1;
        dcnt    <= DCW'(DAC_LEN);
      end else if (dbusy_q && fs_tick) begin
        if (dcnt == DCW'(1)) begin
          dbusy_q <= 1'b0;
          dcnt    <= '0;
        end else begin
          dcnt <= dcnt - DCW'(1);
        end
      end
    end
  end

  assign adc_zero  = abusy_q | ~grp_q | ~grp_on;
  assign dac_zero  = dbusy_q | ~dac_q | ~dac_en;
  assign adc_out_l = adc_zero ? '0 : adc_in_l;
  assign adc_out_r = adc_zero ? '0 : adc_in_r;
  assign dac_out_l = dac_zero ? '0 : dac_in_l;
  assign dac_out_r = dac_zero ? '0 : dac_in_r;
  assign adc_busy  = abusy_q;
  assign dac_busy  = dbusy_q;

  // R1, R6
  a_r1_start: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_on && !grp_q) |=> adc_busy);
  // R2, R8
  a_r2_load_len: assert property (@(posedge clk) disable iff (!rst_n)
    (grp_on && !grp_q) |=> (cnt == sel_len($past(len_sel))));
  // R4
  a_r4_busy_zero: assert property (@(posedge clk) disable iff (!rst_n)
    adc_busy |-> (adc_out_l == '0 && adc_out_r == '0 && cnt != '0));
  // R7, R8
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_busy && grp_on && grp_q && !fs_tick) |=> (adc_busy && $stable(cnt)));
  // R9
  a_r9_abort: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_on |=> (!adc_busy && adc_out_l == '0 && adc_out_r == '0));
  // R10
  a_r10_dac_start: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_en && !dac_q) |=> (dac_busy && dcnt == DCW'(DAC_LEN)));
  // R11
  a_r11_dac_end: assert property (@(posedge clk) disable iff (!rst_n)
    (dac_busy && dac_en && fs_tick && dcnt == DCW'(1)) |=> !dac_busy);

endmodule

// File: tb/codec_init_seq_bench.sv
module codec_init_seq_bench;
  localparam int DW = 24;

  logic clk = 1'b0, rst_n = 1'b0, fs_tick = 1'b0;
  logic [3:0] grp_en = 4'b0;
  logic dac_en = 1'b0;
  logic [1:0] len_sel = 2'b00;
  logic [DW-1:0] adc_in_l = '0, adc_in_r = '0, dac_in_l = '0, dac_in_r = '0;
  logic [DW-1:0] adc_out_l, adc_out_r, dac_out_l, dac_out_r;
  logic adc_busy, dac_busy;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  codec_init_seq #(.DW(DW)) u_codec_init_seq (
    .clk(clk), .rst_n(rst_n), .fs_tick(fs_tick),
    .adc_en_l(grp_en[0]), .adc_en_r(grp_en[1]),
    .mic_en_l(grp_en[2]), .mic_en_r(grp_en[3]),
    .dac_en(dac_en), .len_sel(len_sel),
    .adc_in_l(adc_in_l), .adc_in_r(adc_in_r),
    .dac_in_l(dac_in_l), .dac_in_r(dac_in_r),
    .adc_out_l(adc_out_l), .adc_out_r(adc_out_r),
    .dac_out_l(dac_out_l), .dac_out_r(dac_out_r),
    .adc_busy(adc_busy), .dac_busy(dac_busy));

  function automatic int exp_len(input logic [1:0] s);
    case (s)
      2'b00: return 1059;
      2'b01: return 267;
      2'b10: return 531;
      default: return 135;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe();
    fs_tick = 1'b1;
    @(negedge clk);
    fs_tick = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic adc_window(input logic [1:0] sel, input int src, input bit mid_sel,
                            input bit mid_en, input string req);
    int n = 0, bad = 0;
    grp_en = 4'b0;
    idle(2);
    chk(adc_out_l == 0 && adc_out_r == 0, "R9 off zero", adc_out_l, 0);
    len_sel = sel;
    adc_in_l = 24'h800000 + DW'(src * 4 + sel);
    adc_in_r = 24'h012345 + DW'(sel);
    grp_en[src] = 1'b1;
    @(negedge clk);
    chk(adc_busy == 1'b1, {req, " R1 start"}, adc_busy, 1);
    while (adc_busy && n < 3000) begin
      if (adc_out_l != 0 || adc_out_r != 0) bad++;
      if (mid_sel && n == 5) len_sel = ~sel;
      if (mid_en && n == 7) grp_en[(src + 1) % 4] = 1'b1;
      if (n == 3) begin
        idle(6);
        if (!adc_busy) bad++;
      end
      strobe();
      n++;
    end
    chk(bad == 0, {req, " R4 R8 zero during window"}, bad, 0);
    chk(n == exp_len(sel), {req, " R2 R11 window length"}, n, exp_len(sel));
    chk(adc_out_l == adc_in_l && adc_out_r == adc_in_r, {req, " R5 pass"}, adc_out_l, adc_in_l);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!adc_busy && !dac_busy, "R3 busy after reset", {adc_busy, dac_busy}, 0);
    adc_in_l = 24'h111111;
    dac_in_l = 24'h222222;
    @(negedge clk);
    chk(adc_out_l == 0 && dac_out_l == 0, "R3 outputs zero", adc_out_l | dac_out_l, 0);

    for (int s = 0; s < 4; s++)
      for (int src = 0; src < 4; src++)
        adc_window(2'(s), src, 1'b0, 1'b0, src >= 2 ? "R6" : "R1");

    adc_window(2'b11, 0, 1'b1, 1'b0, "R8 sel change");
    adc_window(2'b01, 1, 1'b0, 1'b1, "R7 second enable");

    grp_en = 4'b0;
    idle(2);
    len_sel = 2'b11;
    grp_en = 4'b0010;
    @(negedge clk);
    repeat (20) strobe();
    chk(adc_busy == 1'b1, "R9 busy before abort", adc_busy, 1);
    grp_en = 4'b0;
    @(negedge clk);
    chk(!adc_busy && adc_out_l == 0 && adc_out_r == 0, "R9 abort", adc_busy, 0);
    adc_window(2'b11, 1, 1'b0, 1'b0, "R9 restart");

    dac_in_l = 24'hABCDEF;
    dac_in_r = 24'h7FFFFF;
    @(negedge clk);
    chk(dac_out_l == 0 && !dac_busy, "R10 dac off zero", dac_out_l, 0);
    for (int rep = 0; rep < 2; rep++) begin
      dac_en = 1'b1;
      @(negedge clk);
      chk(dac_busy && dac_out_l == 0 && dac_out_r == 0, "R10 dac start", dac_busy, 1);
      idle(4);
      chk(dac_busy == 1'b1, "R8 dac no strobe", dac_busy, 1);
      strobe();
      chk(dac_busy && dac_out_r == 0, "R11 dac after 1", dac_busy, 1);
      strobe();
      chk(!dac_busy, "R11 dac after 2", dac_busy, 0);
      chk(dac_out_l == dac_in_l && dac_out_r == dac_in_r, "R10 dac pass", dac_out_l, dac_in_l);
      dac_en = 1'b0;
      @(negedge clk);
      chk(dac_out_l == 0 && !dac_busy, "R10 dac disabled", dac_out_l, 0);
    end
    summary();
  end
endmodule